// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It does this by reading two page-table entries from memory. A request carries the virtual address, a read/write flag and the page number of the root table, which is held in a pointer register outside the block.

The walk works in two steps:
- The upper ten address bits pick an entry in the root table. The root table is one 4-kbyte page holding 1024 word-sized entries. That entry names the page holding a second-level table.
- The next ten bits pick an entry in the second-level table. That entry supplies the frame number. The low twelve bits pass through unchanged as the page offset.

Entry layout:
- bit 0 is the present flag;
- bit 1 is the modified flag;
- bits 11:2 hold other control flags, which the walker ignores;
- bits 31:12 hold the page number of the next table or of the frame.

If the present flag is clear at either level, the walk stops and the block reports a page fault with the level that failed. When a write access finds a final entry whose modified flag is clear, the walker first writes that entry back with the flag set, and only then completes.

The memory side is a single port with one read or write in flight at a time. The walker raises a request for one cycle. Memory answers each access, including a write, with a one-cycle valid pulse. A new translation is accepted only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: During and straight after reset, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: The first memory access of a walk is a read (`mem_we`=0) at address {`root_pn`, vaddr[31:22], 2'b00}. Here `root_pn` is the value captured when the request was accepted.
- R3: When the root entry has bit 0 set, the second access is a read at address {root entry[31:12], vaddr[21:12], 2'b00}.
- R4: When the second-level entry has bit 0 set, `resp_paddr` is {second entry[31:12], vaddr[11:0]} and `resp_fault` is 0. Entry bits 11:2 do not affect the address.
- R5: When the root entry has bit 0 clear, the walk makes no further access. It reports `resp_fault`=1, `resp_fault_lvl`=0 and `resp_paddr`=0.
- R6: When the second-level entry has bit 0 clear, the walk reports `resp_fault`=1, `resp_fault_lvl`=1 and `resp_paddr`=0. It makes no write, even for a write access.
- R7: On a write access (`req_write`=1) whose second-level entry has bit 0 set and bit 1 clear, the walker writes that entry back to the same address with bit 1 set. The write happens before the response is given.
- R8: A read access, or a write access whose second-level entry already has bit 1 set, causes no memory write.
- R9: `mem_req` is never raised while an earlier access has not yet been answered by `mem_rvalid`.
- R10: `req_ready` is 0 from acceptance until after the response. A `req_valid` seen while busy starts no walk and produces no response.
- R11: `resp_valid` is a one-cycle pulse. It rises n·(1+L) clock edges after the accepting edge, where n is the number of memory accesses in the walk and L is the number of edges from a request until its `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| root_pn | input | 20 | Page number of the root table, from the pointer register |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | 1 when the access is an entry write-back |
| mem_addr | output | 32 | Byte address of the entry accessed |
| mem_wdata | output | 32 | Entry value for a write-back |
| mem_rvalid | input | 1 | Access answered; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Page fault: an entry was not present |
| resp_fault_lvl | output | 1 | Level that faulted: 0 root, 1 second |
| resp_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
Each memory access costs 1+L edges: one cycle to issue the request, then L edges until its answer. The response is therefore due 2(1+L), 1(1+L) or 3(1+L) edges after acceptance, for a normal walk, a root fault and a walk with a write-back respectively. The scoreboard stores that count for each request and measures the elapsed edges when the pulse appears, sampling on the falling edge. Every memory request is also compared, as it appears, against the access sequence worked out from the memory image, so a missing, extra or early access is reported at the cycle it happens.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTE_P_BIT = 0;
    localparam int PTE_M_BIT = 1;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RT_REQ,
        WS_RT_WAIT,
        WS_LF_REQ,
        WS_LF_WAIT,
        WS_WB_REQ,
        WS_WB_WAIT,
        WS_DONE
    } walk_st_e;

endpackage

// File: rtl/ptw_ent_addr.sv
module ptw_ent_addr #(
    parameter int PN_W  = 20,
    parameter int IDX_W = 10,
    parameter int SH_W  = 2
) (
    input  logic [PN_W-1:0]            base_pn,
    input  logic [IDX_W-1:0]           index,
    output logic [PN_W+IDX_W+SH_W-1:0] addr
);
    // entries are word sized: the index is scaled by the entry size
    assign addr = {base_pn, index, {SH_W{1'b0}}};
endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec import ptw_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       pte,
    output logic                    present,
    output logic                    dirty,
    output logic [ADDR_W-OFF_W-1:0] next_pn,
    output logic [ADDR_W-1:0]       marked
);
    assign present = pte[PTE_P_BIT];
    assign dirty   = pte[PTE_M_BIT];
    assign next_pn = pte[ADDR_W-1:OFF_W];
    assign marked  = pte | (ADDR_W'(1) << PTE_M_BIT);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic [ADDR_W-OFF_W-1:0] root_pn,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W-1:0]       mem_wdata,
    input  logic                    mem_rvalid,
    input  logic [ADDR_W-1:0]       mem_rdata,
    output logic                    resp_valid,
    output logic                    resp_fault,
    output logic                    resp_fault_lvl,
    output logic [ADDR_W-1:0]       resp_paddr
);
    localparam int PN_W   = ADDR_W - OFF_W;
    localparam int SH_W   = OFF_W - IDX_W;
    localparam int LEVELS = PN_W / IDX_W;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic              wr;
        logic [PN_W-1:0]   tbl;
        logic [ADDR_W-1:0] pte;
        logic              flt;
        logic              lvl;
        logic [ADDR_W-1:0] pa;
    } walk_s;

    walk_s q, d;

    // per-level index slices of the held virtual address
    logic [IDX_W-1:0] lvl_idx [LEVELS];
    genvar lv;
    generate
        for (lv = 0; lv < LEVELS; lv++) begin : g_idx
            assign lvl_idx[lv] = q.va[ADDR_W-1-lv*IDX_W -: IDX_W];
        end
    endgenerate

    logic [IDX_W-1:0] cur_idx;
    assign cur_idx = (q.st == WS_RT_REQ) ? lvl_idx[0] : lvl_idx[LEVELS-1];

    ptw_ent_addr #(.PN_W(PN_W), .IDX_W(IDX_W), .SH_W(SH_W)) ent_addr_i (
        .base_pn (q.tbl),
        .index   (cur_idx),
        .addr    (mem_addr)
    );

    logic            rd_present;
    logic            rd_dirty;
    logic [PN_W-1:0] rd_pn;
    logic [ADDR_W-1:0] rd_marked;

    ptw_pte_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) pte_dec_i (
        .pte     (mem_rdata),
        .present (rd_present),
        .dirty   (rd_dirty),
        .next_pn (rd_pn),
        .marked  (rd_marked)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    d.st  = WS_RT_REQ;
                    d.va  = req_vaddr;
                    d.wr  = req_write;
                    d.tbl = root_pn;
                    d.flt = 1'b0;
                    d.lvl = 1'b0;
                    d.pa  = '0;
                end
            end
            WS_RT_REQ: d.st = WS_RT_WAIT;
            WS_RT_WAIT: begin
                if (mem_rvalid) begin
                    if (!rd_present) begin
                        d.st  = WS_DONE;
                        d.flt = 1'b1;
                        d.lvl = 1'b0;
                    end else begin
                        d.tbl = rd_pn;
                        d.st  = WS_LF_REQ;
                    end
                end
            end
            WS_LF_REQ: d.st = WS_LF_WAIT;
            WS_LF_WAIT: begin
                if (mem_rvalid) begin
                    if (!rd_present) begin
                        d.st  = WS_DONE;
                        d.flt = 1'b1;
                        d.lvl = 1'b1;
                    end else begin
                        d.pa  = {rd_pn, q.va[OFF_W-1:0]};
                        d.pte = rd_marked;
                        d.st  = (q.wr && !rd_dirty) ? WS_WB_REQ : WS_DONE;
                    end
                end
            end
            WS_WB_REQ: d.st = WS_WB_WAIT;
            WS_WB_WAIT: begin
                if (mem_rvalid) d.st = WS_DONE;
            end
            WS_DONE: d.st = WS_IDLE;
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready      = (q.st == WS_IDLE);
    assign mem_req        = (q.st == WS_RT_REQ) || (q.st == WS_LF_REQ) || (q.st == WS_WB_REQ);
    assign mem_we         = (q.st == WS_WB_REQ);
    assign mem_wdata      = q.pte;
    assign resp_valid     = (q.st == WS_DONE);
    assign resp_fault     = q.flt;
    assign resp_fault_lvl = q.lvl;
    assign resp_paddr     = q.pa;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk import ptw_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       req_vaddr,
    input logic [ADDR_W-OFF_W-1:0] root_pn,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [ADDR_W-1:0]       mem_wdata,
    input logic                    mem_rvalid,
    input logic [ADDR_W-1:0]       mem_rdata,
    input logic                    resp_valid,
    input logic                    resp_fault,
    input logic                    resp_fault_lvl,
    input logic [ADDR_W-1:0]       resp_paddr
);
    localparam int PN_W = ADDR_W - OFF_W;
    localparam int SH_W = OFF_W - IDX_W;

    logic              outst_q;
    logic              wpend_q;
    logic [1:0]        nreq_q;
    logic [IDX_W-1:0]  hi_q;
    logic [IDX_W-1:0]  mid_q;
    logic [OFF_W-1:0]  off_q;
    logic [PN_W-1:0]   root_q;
    logic [ADDR_W-1:0] la_q;
    logic [ADDR_W-1:0] ld_q;
    logic              accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
            wpend_q <= 1'b0;
            nreq_q  <= '0;
            hi_q    <= '0;
            mid_q   <= '0;
            off_q   <= '0;
            root_q  <= '0;
            la_q    <= '0;
            ld_q    <= '0;
        end else begin
            if (mem_req) outst_q <= 1'b1;
            else if (mem_rvalid) outst_q <= 1'b0;
            if (mem_req) begin
                wpend_q <= mem_we;
                la_q    <= mem_addr;
            end
            if (mem_rvalid && !wpend_q) ld_q <= mem_rdata;
            if (accept) begin
                nreq_q <= '0;
                hi_q   <= req_vaddr[ADDR_W-1 -: IDX_W];
                mid_q  <= req_vaddr[ADDR_W-1-IDX_W -: IDX_W];
                off_q  <= req_vaddr[OFF_W-1:0];
                root_q <= root_pn;
            end else if (mem_req && nreq_q != 2'd3) begin
                nreq_q <= nreq_q + 2'd1;
            end
        end
    end

    // R2
    root_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && nreq_q == 2'd0 |-> !mem_we && mem_addr == {root_q, hi_q, {SH_W{1'b0}}});

    // R3
    leaf_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && nreq_q == 2'd1 |-> !mem_we && mem_addr == {ld_q[ADDR_W-1:OFF_W], mid_q, {SH_W{1'b0}}});

    // R7
    wb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && nreq_q == 2'd2 |-> mem_we && mem_addr == la_q
            && mem_wdata == (ld_q | (ADDR_W'(1) << PTE_M_BIT)));

    // R4
    paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_fault |-> resp_paddr == {ld_q[ADDR_W-1:OFF_W], off_q});

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == '0);

    // R6
    fault_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_fault_lvl == (nreq_q == 2'd2));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst_q);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || resp_valid) |-> !req_ready);

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .root_pn        (root_pn),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .resp_valid     (resp_valid),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl),
    .resp_paddr     (resp_paddr)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [19:0] root_pn = 20'h00010;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic        resp_fault_lvl;
    logic [31:0] resp_paddr;

    always #2 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .root_pn(root_pn),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_fault_lvl(resp_fault_lvl), .resp_paddr(resp_paddr)
    );

    typedef struct {
        bit        flt;
        bit        lvl;
        bit [31:0] pa;
        int        lat;
        string     tag;
    } exp_t;

    typedef struct {
        bit        we;
        bit [31:0] a;
        bit [31:0] d;
        string     tag;
    } acc_t;

    exp_t      sbq[$];
    acc_t      accq[$];
    bit [31:0] pmem [bit [31:0]];
    int        total = 0;
    int        bad = 0;
    int        cyc = 0;
    int        t_acc = 0;
    int        mem_lat = 1;
    int        cnt = 0;
    bit [31:0] pend_rd = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] rd(input bit [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // memory model: compares each access against the expected sequence
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pend_rd;
            end
        end
        if (rst_n && mem_req) begin
            if (accq.size() == 0) begin
                chk(1'b0, "R8 unexpected access", mem_addr, 32'h0);
            end else begin
                acc_t e;
                e = accq.pop_front();
                chk(mem_addr == e.a, {e.tag, " addr"}, mem_addr, e.a);
                chk(mem_we == e.we, {e.tag, " we"}, {31'h0, mem_we}, {31'h0, e.we});
                if (e.we) chk(mem_wdata == e.d, {e.tag, " wdata"}, mem_wdata, e.d);
            end
            if (mem_we) pmem[mem_addr] = mem_wdata;
            pend_rd = rd(mem_addr);
            cnt = mem_lat;
        end
    end

    // monitor: pops scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10 unexpected response", resp_paddr, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(resp_fault == e.flt, {e.tag, " fault"}, {31'h0, resp_fault}, {31'h0, e.flt});
                if (e.flt) chk(resp_fault_lvl == e.lvl, {e.tag, " level"},
                               {31'h0, resp_fault_lvl}, {31'h0, e.lvl});
                chk(resp_paddr == e.pa, {e.tag, " paddr"}, resp_paddr, e.pa);
                chk((cyc - t_acc) == e.lat, "R11 latency", 32'(cyc - t_acc), 32'(e.lat));
            end
        end
    end

    task automatic walk(input bit [31:0] va, input bit wr, input int lat_l,
                        input bit junk, input string tag);
        bit [31:0] a1, a2, e1, e2;
        exp_t x;
        int n;
        mem_lat = lat_l;
        a1 = {root_pn, va[31:22], 2'b00};
        e1 = rd(a1);
        accq.push_back('{1'b0, a1, 32'h0, "R2 root read"});
        x.pa = '0; x.flt = 1'b0; x.lvl = 1'b0; x.tag = tag;
        if (!e1[0]) begin
            x.flt = 1'b1; x.lvl = 1'b0; n = 1;
        end else begin
            a2 = {e1[31:12], va[21:12], 2'b00};
            e2 = rd(a2);
            accq.push_back('{1'b0, a2, 32'h0, "R3 leaf read"});
            if (!e2[0]) begin
                x.flt = 1'b1; x.lvl = 1'b1; n = 2;
            end else begin
                x.pa = {e2[31:12], va[11:0]};
                n = 2;
                if (wr && !e2[1]) begin
                    accq.push_back('{1'b1, a2, e2 | 32'h2, "R7 write-back"});
                    n = 3;
                end
            end
        end
        x.lat = n * (1 + lat_l);
        sbq.push_back(x);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(posedge clk);
        #1 t_acc = cyc;
        @(negedge clk);
        if (junk) begin
            req_vaddr = 32'h00803000;
            req_write = 1'b1;
            repeat (3) begin
                chk(req_ready == 1'b0, "R10 ready while busy", {31'h0, req_ready}, 32'h0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        pmem[32'h00010004] = 32'h00020001;
        pmem[32'h0002000C] = 32'h12345FFD;
        pmem[32'h00010FFC] = 32'h00ABC7F9;
        pmem[32'h00ABCFFC] = 32'hFEDCB003;
        pmem[32'h00010000] = 32'h00030001;
        pmem[32'h00030000] = 32'h0BEEF001;
        pmem[32'h00040004] = 32'h00050001;
        pmem[32'h0005000C] = 32'h7777700F;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'h0, req_ready}, 32'h1);
        chk(resp_valid == 1'b0, "R1 resp in reset", {31'h0, resp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req in reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        chk(resp_valid == 1'b0, "R1 resp after reset", {31'h0, resp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", {31'h0, mem_req}, 32'h0);

        walk(32'h00403ABC, 1'b0, 1, 1'b0, "R4 read, control bits ignored, R8");
        walk(32'h00403ABC, 1'b1, 1, 1'b0, "R7 write with clean entry");
        chk(rd(32'h0002000C) == 32'h12345FFF, "R7 entry marked", rd(32'h0002000C), 32'h12345FFF);
        walk(32'h00403ABC, 1'b1, 1, 1'b0, "R8 write with marked entry");
        walk(32'h00803000, 1'b1, 1, 1'b0, "R5 root fault");
        walk(32'h00404123, 1'b1, 1, 1'b0, "R6 leaf fault");
        walk(32'hFFFFFFFF, 1'b0, 3, 1'b0, "R4 top indices");
        walk(32'h00000000, 1'b1, 3, 1'b0, "R7 zero indices");
        walk(32'h00403ABC, 1'b0, 3, 1'b1, "R10 busy request ignored");
        root_pn = 20'h00040;
        walk(32'h00403ABC, 1'b0, 2, 1'b0, "R2 other root base");

        chk(accq.size() == 0, "R9 access count", 32'(accq.size()), 32'h0);
        chk(sbq.size() == 0, "R10 response count", 32'(sbq.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule